// File: doc/BRIEF.md
# Byte-Lane Splitting Bus Bridge

This block sits between a 32-bit memory-mapped master port and a slow external device with an 8-bit asynchronous data bus and one chip select. The device may be a dual-port RAM or a fieldbus controller. Reading some of the controller's registers changes its state, for example by clearing status flags. The master always issues reads as full words, whatever width the software asked for, so the byte enables are the only record of which bytes are wanted.

The bridge turns each master access into a series of external byte cycles, one for each enabled byte lane, in ascending lane order. Lanes that are not enabled are never touched on the external bus. On a read they come back as zero, so a side effect on the device happens only for a byte that software really requested.

Writes are split the same way. The master is stalled with a wait request until the last external cycle has finished.

Top module: `byte_lane_bridge`

## Requirements
- R1: After reset, `m_waitreq` is 1, and `ext_cs`, `ext_rd`, `ext_wr`, `ext_doe` and `m_rvalid` are 0.
- R2: A read runs exactly one external read strobe for each byte lane whose enable bit `m_byteen[i]` is 1, and none for a lane whose bit is 0.
- R3: In the assembled read word, bits 8i+7..8i hold the byte read from lane i when `m_byteen[i]` is 1, and 0x00 when it is 0.
- R4: A write runs exactly one external write strobe for each enabled lane i, carrying `m_wdata[8i+7:8i]`. Device bytes of lanes that are not enabled keep their contents.
- R5: Enabled lanes are accessed in ascending lane order. The external address is `m_addr*4 + i`: the lane index sits in the low 2 bits and the word address above it.
- R6: Each lane cycle raises chip select for one cycle before the strobe. The strobe then stays high for WAIT_CYC cycles, with chip select still high. One cycle follows with chip select and both strobes low.
- R7: `m_waitreq` stays 1 from the cycle the request is sampled until the last lane has finished. It then drops to 0 for one cycle, N*(WAIT_CYC+2)+1 cycles after the sampling edge, where N is the number of enabled lanes.
- R8: `m_rvalid` pulses for one cycle, in the cycle after `m_waitreq` was low, for reads only.
- R9: An access with all byte enables at 0 runs no external cycle. It releases `m_waitreq` in the first cycle after sampling, and a read returns 0x00000000.
- R10: `ext_doe`, which enables the external data output, is 1 only while a write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_addr | input | WORD_AW | Word address from the master |
| m_read | input | 1 | Read request, held while `m_waitreq` is 1 |
| m_write | input | 1 | Write request, held while `m_waitreq` is 1 |
| m_byteen | input | 4 | Byte enables, bit i selects lane i |
| m_wdata | input | 32 | Write data |
| m_waitreq | output | 1 | Stall to the master; 0 marks acceptance |
| m_rdata | output | 32 | Assembled read data |
| m_rvalid | output | 1 | Read data valid pulse |
| ext_addr | output | WORD_AW+2 | External byte address |
| ext_cs | output | 1 | External chip select, active high |
| ext_rd | output | 1 | External read strobe, active high |
| ext_wr | output | 1 | External write strobe, active high |
| ext_dout | output | 8 | Byte driven toward the device |
| ext_doe | output | 1 | Output enable for `ext_dout` |
| ext_din | input | 8 | Byte returned by the device |

## Verification
If the pending-lane mask is corrupted, it shows up on the external bus within one lane cycle: an extra read strobe on a lane that was not enabled, or a missing one. The device model counts these per address. A wrong lane index puts the byte into the wrong slice of `m_rdata`, or takes the wrong slice of `m_wdata`, and is caught when the word is returned or read back. A fault in the strobe timer or in the state sequence changes the strobe width or the release cycle of `m_waitreq`. Both are measured to the exact cycle on every access.

// File: rtl/blb_pkg.sv
package blb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_GAP,
    ST_DONE,
    ST_RESP
  } seq_state_t;
endpackage

// File: rtl/blb_lane_picker.sv
// Lowest-index set bit of a lane mask.
module blb_lane_picker #(
  parameter int LANES = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] mask,
  output logic [LW-1:0]    idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    any = |mask;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask[i]) idx = LW'(i);
    end
  end
endmodule

// File: rtl/blb_strobe_timer.sv
// Counts the strobe cycles of one lane access.
module blb_strobe_timer #(
  parameter int WAIT_CYC = 2,
  localparam int CW = $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= CW'(WAIT_CYC - 1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/blb_rdata_assembler.sv
// One byte register per lane; cleared at the start of every access.
module blb_rdata_assembler #(
  parameter int LANES = 4,
  parameter int E_DW  = 8,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  cap_en,
  input  logic [LW-1:0]         cap_idx,
  input  logic [E_DW-1:0]       cap_byte,
  output logic [LANES*E_DW-1:0] word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [E_DW-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst || clear)                         byte_q <= '0;
      else if (cap_en && (cap_idx == LW'(g)))   byte_q <= cap_byte;
    end
    assign word[g*E_DW +: E_DW] = byte_q;
  end
endmodule

// File: rtl/byte_lane_bridge.sv
module byte_lane_bridge
  import blb_pkg::*;
#(
  parameter int WORD_AW  = 6,
  parameter int M_DW     = 32,
  parameter int E_DW     = 8,
  parameter int WAIT_CYC = 2,
  localparam int LANES = M_DW / E_DW,
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int EAW   = WORD_AW + LW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WORD_AW-1:0] m_addr,
  input  logic               m_read,
  input  logic               m_write,
  input  logic [LANES-1:0]   m_byteen,
  input  logic [M_DW-1:0]    m_wdata,
  output logic               m_waitreq,
  output logic [M_DW-1:0]    m_rdata,
  output logic               m_rvalid,
  output logic [EAW-1:0]     ext_addr,
  output logic               ext_cs,
  output logic               ext_rd,
  output logic               ext_wr,
  output logic [E_DW-1:0]    ext_dout,
  output logic               ext_doe,
  input  logic [E_DW-1:0]    ext_din
);
  seq_state_t state_q, nxt;

  logic [WORD_AW-1:0] waddr_q;
  logic [M_DW-1:0]    wdata_q;
  logic [LANES-1:0]   pend_q;
  logic [LW-1:0]      cur_q;
  logic               is_rd_q;

  logic               req;
  logic [LANES-1:0]   pick_mask;
  logic [LW-1:0]      pick_idx;
  logic               pick_any;
  logic               tmr_load;
  logic               tmr_done;
  logic               cap_en;
  logic               asm_clear;
  logic [WORD_AW-1:0] sel_addr;
  logic [M_DW-1:0]    sel_wdata;

  logic               waitreq_q, rvalid_q;
  logic               cs_q, rd_q, wr_q, doe_q;
  logic [EAW-1:0]     eaddr_q;
  logic [E_DW-1:0]    dout_q;

  assign req       = m_read | m_write;
  assign pick_mask = (state_q == ST_IDLE) ? m_byteen : pend_q;
  assign sel_addr  = (state_q == ST_IDLE) ? m_addr   : waddr_q;
  assign sel_wdata = (state_q == ST_IDLE) ? m_wdata  : wdata_q;

  blb_lane_picker #(.LANES(LANES)) picker_i (
    .mask (pick_mask),
    .idx  (pick_idx),
    .any  (pick_any)
  );

  assign tmr_load = (state_q == ST_SETUP);

  blb_strobe_timer #(.WAIT_CYC(WAIT_CYC)) timer_i (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .done (tmr_done)
  );

  assign cap_en    = (state_q == ST_STROBE) && tmr_done && is_rd_q;
  assign asm_clear = (state_q == ST_IDLE) && req;

  blb_rdata_assembler #(.LANES(LANES), .E_DW(E_DW)) asm_i (
    .clk      (clk),
    .rst      (rst),
    .clear    (asm_clear),
    .cap_en   (cap_en),
    .cap_idx  (cur_q),
    .cap_byte (ext_din),
    .word     (m_rdata)
  );

  // Next-state decode
  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_IDLE:   if (req) nxt = pick_any ? ST_SETUP : ST_DONE;
      ST_SETUP:  nxt = ST_STROBE;
      ST_STROBE: if (tmr_done) nxt = ST_GAP;
      ST_GAP:    nxt = pick_any ? ST_SETUP : ST_DONE;
      ST_DONE:   nxt = ST_RESP;
      ST_RESP:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  // Sequencer state and access context
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      waddr_q <= '0;
      wdata_q <= '0;
      pend_q  <= '0;
      cur_q   <= '0;
      is_rd_q <= 1'b0;
    end else begin
      state_q <= nxt;
      if (state_q == ST_IDLE && req) begin
        waddr_q <= m_addr;
        wdata_q <= m_wdata;
        pend_q  <= m_byteen;
        is_rd_q <= m_read;
      end
      if (nxt == ST_SETUP) cur_q <= pick_idx;
      if (state_q == ST_STROBE && tmr_done) pend_q[cur_q] <= 1'b0;
    end
  end

  // Registered outputs, computed from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      waitreq_q <= 1'b1;
      rvalid_q  <= 1'b0;
      cs_q      <= 1'b0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      doe_q     <= 1'b0;
      eaddr_q   <= '0;
      dout_q    <= '0;
    end else begin
      waitreq_q <= (nxt != ST_DONE);
      rvalid_q  <= (nxt == ST_RESP) && is_rd_q;
      cs_q      <= (nxt == ST_SETUP) || (nxt == ST_STROBE);
      rd_q      <= (nxt == ST_STROBE) && is_rd_q;
      wr_q      <= (nxt == ST_STROBE) && !is_rd_q;
      doe_q     <= (nxt == ST_STROBE) && !is_rd_q;
      if (nxt == ST_SETUP) begin
        eaddr_q <= {sel_addr, pick_idx};
        dout_q  <= sel_wdata[pick_idx*E_DW +: E_DW];
      end
    end
  end

  assign m_waitreq = waitreq_q;
  assign m_rvalid  = rvalid_q;
  assign ext_cs    = cs_q;
  assign ext_rd    = rd_q;
  assign ext_wr    = wr_q;
  assign ext_doe   = doe_q;
  assign ext_addr  = eaddr_q;
  assign ext_dout  = dout_q;
endmodule

// File: rtl/blb_checker.sv
module blb_checker #(
  parameter int WORD_AW  = 6,
  parameter int WAIT_CYC = 2,
  localparam int EAW = WORD_AW + 2,
  localparam int RW  = $clog2(WAIT_CYC + 2)
) (
  input logic           clk,
  input logic           rst,
  input logic           m_read,
  input logic [3:0]     m_byteen,
  input logic           m_waitreq,
  input logic           m_rvalid,
  input logic [EAW-1:0] ext_addr,
  input logic           ext_cs,
  input logic           ext_rd,
  input logic           ext_wr,
  input logic           ext_doe
);
  logic          strobe;
  logic [RW-1:0] run_q;

  assign strobe = ext_rd | ext_wr;

  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (strobe) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  assert_rd_lane_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    ext_rd |-> (m_read && m_byteen[ext_addr[1:0]]));

  assert_strobe_in_cs_R6: assert property (@(posedge clk) disable iff (rst)
    strobe |-> ext_cs);

  assert_setup_before_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe) |-> $past(ext_cs));

  assert_gap_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe) |-> !ext_cs);

  assert_strobe_width_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe) |-> (run_q == RW'(WAIT_CYC)));

  assert_no_bus_on_release_R7: assert property (@(posedge clk) disable iff (rst)
    !m_waitreq |-> !ext_cs);

  assert_rvalid_after_release_R8: assert property (@(posedge clk) disable iff (rst)
    m_rvalid |-> $past(!m_waitreq));

  assert_doe_in_write_R10: assert property (@(posedge clk) disable iff (rst)
    ext_doe |-> ext_wr);

  assert_rd_wr_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(ext_rd && ext_wr));
endmodule

bind byte_lane_bridge blb_checker #(.WORD_AW(WORD_AW), .WAIT_CYC(WAIT_CYC)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .m_read    (m_read),
  .m_byteen  (m_byteen),
  .m_waitreq (m_waitreq),
  .m_rvalid  (m_rvalid),
  .ext_addr  (ext_addr),
  .ext_cs    (ext_cs),
  .ext_rd    (ext_rd),
  .ext_wr    (ext_wr),
  .ext_doe   (ext_doe)
);

// File: tb/byte_lane_bridge_tb_top.sv
`timescale 1ns/1ps
module byte_lane_bridge_tb_top;
  localparam int WORD_AW = 6;
  localparam int W       = 2;
  localparam int NBYTES  = 4 << WORD_AW;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [WORD_AW-1:0] m_addr = '0;
  logic               m_read = 1'b0;
  logic               m_write = 1'b0;
  logic [3:0]         m_byteen = '0;
  logic [31:0]        m_wdata = '0;
  logic               m_waitreq;
  logic [31:0]        m_rdata;
  logic               m_rvalid;
  logic [WORD_AW+1:0] ext_addr;
  logic               ext_cs, ext_rd, ext_wr, ext_doe;
  logic [7:0]         ext_dout;
  logic [7:0]         ext_din;

  always #2 clk = ~clk;

  byte_lane_bridge #(.WORD_AW(WORD_AW), .WAIT_CYC(W)) dut_i (
    .clk(clk), .rst(rst), .m_addr(m_addr), .m_read(m_read), .m_write(m_write),
    .m_byteen(m_byteen), .m_wdata(m_wdata), .m_waitreq(m_waitreq),
    .m_rdata(m_rdata), .m_rvalid(m_rvalid), .ext_addr(ext_addr),
    .ext_cs(ext_cs), .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_dout(ext_dout),
    .ext_doe(ext_doe), .ext_din(ext_din)
  );

  // Device model: byte memory, logs each strobe start, measures widths
  logic [7:0] mem [NBYTES];
  logic [7:0] shadow [NBYTES];
  int         ev_n;
  int         ev_addr [16];
  bit         ev_wr [16];
  int         width_err;
  int         run;
  logic       prev_st;

  assign ext_din = (ext_cs && ext_rd) ? mem[ext_addr] : 8'hEE;

  initial begin
    for (int i = 0; i < NBYTES; i++) mem[i] = 8'(i * 37 + 5);
  end

  always @(posedge clk) begin
    if (rst) begin
      prev_st = 1'b0; run = 0;
    end else begin
      if ((ext_rd || ext_wr) && !prev_st) begin
        if (ev_n < 16) begin
          ev_addr[ev_n] = int'(ext_addr);
          ev_wr[ev_n]   = ext_wr;
        end
        ev_n++;
        if (ext_wr && ext_doe) mem[ext_addr] = ext_dout;
      end
      if (ext_rd || ext_wr) run++;
      else begin
        if (prev_st && run != W) width_err++;
        run = 0;
      end
      prev_st = ext_rd || ext_wr;
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [3:0] be);
    int c = 0;
    for (int i = 0; i < 4; i++) if (be[i]) c++;
    return c;
  endfunction

  // Checks the event log against the enabled lanes (R2, R4, R5)
  task automatic chk_log(input logic [WORD_AW-1:0] a, input logic [3:0] be, input bit wr, input string req);
    int k = 0;
    chk(ev_n == popc(be), req, 32'(ev_n), 32'(popc(be)));
    for (int i = 0; i < 4; i++) begin
      if (be[i] && k < ev_n && k < 16) begin
        chk(ev_addr[k] == int'({a, 2'(i)}) && ev_wr[k] == wr, "R5",
            32'(ev_addr[k]), 32'({a, 2'(i)}));
        k++;
      end
    end
  endtask

  task automatic run_access(input logic [WORD_AW-1:0] a, input logic [3:0] be,
                            input bit wr, input logic [31:0] wd, output int cyc);
    @(negedge clk);
    ev_n = 0;
    m_addr = a; m_byteen = be; m_wdata = wd;
    m_read = !wr; m_write = wr;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (m_waitreq && cyc < 1000);
    @(posedge clk);
    #1;
    m_read = 1'b0; m_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(m_waitreq == 1'b1, "R1", 32'(m_waitreq), 32'd1);
    chk({ext_cs, ext_rd, ext_wr, ext_doe, m_rvalid} == 5'b0, "R1",
        32'({ext_cs, ext_rd, ext_wr, ext_doe, m_rvalid}), 32'd0);
    @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic t_read(input logic [WORD_AW-1:0] a, input logic [3:0] be);
    int cyc;
    logic [31:0] exp;
    for (int i = 0; i < 4; i++) exp[i*8 +: 8] = be[i] ? mem[{a, 2'(i)}] : 8'h00;
    run_access(a, be, 1'b0, 32'h0, cyc);
    chk(cyc == popc(be) * (W + 2) + 1, be == 0 ? "R9" : "R7", 32'(cyc), 32'(popc(be) * (W + 2) + 1));
    chk(m_rvalid == 1'b1, "R8", 32'(m_rvalid), 32'd1);
    chk(m_rdata == exp, be == 0 ? "R9" : "R3", m_rdata, exp);
    chk_log(a, be, 1'b0, "R2");
    @(negedge clk);
    chk(m_rvalid == 1'b0, "R8", 32'(m_rvalid), 32'd0);
  endtask

  task automatic t_write(input logic [WORD_AW-1:0] a, input logic [3:0] be, input logic [31:0] wd);
    int cyc;
    bit ok = 1'b1;
    for (int i = 0; i < NBYTES; i++) shadow[i] = mem[i];
    for (int i = 0; i < 4; i++) if (be[i]) shadow[{a, 2'(i)}] = wd[i*8 +: 8];
    run_access(a, be, 1'b1, wd, cyc);
    chk(cyc == popc(be) * (W + 2) + 1, be == 0 ? "R9" : "R7", 32'(cyc), 32'(popc(be) * (W + 2) + 1));
    chk(m_rvalid == 1'b0, "R8", 32'(m_rvalid), 32'd0);
    chk_log(a, be, 1'b1, "R4");
    for (int i = 0; i < NBYTES; i++) if (mem[i] !== shadow[i]) ok = 1'b0;
    chk(ok, "R4", {24'h0, mem[{a, 2'b00}]}, {24'h0, shadow[{a, 2'b00}]});
  endtask

  initial begin
    ev_n = 0; width_err = 0;
    t_reset();
    t_read(6'd3, 4'b1111);
    t_read(6'd5, 4'b0100);
    t_read(6'd9, 4'b1100);
    t_read(6'd12, 4'b1010);
    t_read(6'd7, 4'b0000);
    t_write(6'd20, 4'b0010, 32'hA1B2C3D4);
    t_write(6'd21, 4'b0011, 32'h11223344);
    t_write(6'd22, 4'b1111, 32'hDEADBEEF);
    t_write(6'd23, 4'b0000, 32'h55555555);
    t_write(6'd24, 4'b1001, 32'h0BADF00D);
    t_read(6'd22, 4'b1111);
    t_read(6'd24, 4'b0110);
    chk(width_err == 0, "R6", 32'(width_err), 32'd0);
    chk(ext_doe == 1'b0, "R10", 32'(ext_doe), 32'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule